// File: doc/BRIEF.md
# SD Host Status and Interrupt Register Block

This block keeps the status flags of an SD card host controller, the host configuration enables and a debug/state register, and folds three of the status flags into one level-sensitive interrupt line. The command and data engines of the host report events by pulsing per-bit set strobes. Software reads the flags over a simple 32-bit register bus and acknowledges them by writing ones to the status offset.

The configuration enables are driven out to the neighbouring engines, which decide from them whether to raise the interrupt-class flags. The debug register comes out of reset in a power-down state. A software write whose low nibble is all ones is stored with that nibble cleared, so software cannot put the state field into the power-down-start code. Writes to the timeout and clock-divider offsets are accepted and discarded. The read mux returns zero for every offset that is not held here.

Top module: `sd_host_status`

## Requirements
- R1: While and right after reset, status reads 0, configuration reads 0, the debug register reads 0x0000C60F and `irq` is low.
- R2: A high bit in `sts_set` sets the matching status bit at the next clock edge. The bit then stays set until software clears it.
- R3: A bus write to offset 0x20 clears every status bit whose written bit is 1 and leaves every bit written as 0 unchanged.
- R4: If a set strobe and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when status bit 10 (busy), 9 (block) or 8 (data/SDIO) is set. Bits 7 (read timeout), 6 (command timeout), 5 (CRC16), 4 (CRC7), 3 (FIFO error) and 0 (data flag) never raise it.
- R6: A write to offset 0x38 stores configuration bits 10, 8, 5, 4, 3, 2, 1 and 0 (mask 0x53F) and drives them on `cfg_out`. All other configuration bits read 0.
- R7: A write to offset 0x34 stores the written value, except that when bits 3:0 are 0xF those four bits are stored as 0.
- R8: Writes to offsets 0x08 and 0x0C, and to any offset other than 0x20, 0x34 and 0x38, change no register. Reads of any offset other than 0x20, 0x34 and 0x38 return 0.
- R9: Status bits 2 and 1 are reserved. They read 0 even when their set strobes are pulsed.
- R10: `bus_rdata` shows the current contents of the register selected by `bus_addr` in the same cycle, with no read strobe and no read side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sts_set | input | 11 | Per-bit status set strobes from the command and data engines |
| cfg_out | output | 11 | Stored configuration enables |
| dbg_out | output | 32 | Stored debug/state register |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit data, 8-bit offsets, an 11-bit status field and the 0x0000C60F debug reset value. These values place every interrupt-class bit, every error bit and both reserved bits under direct stimulus. With the 8-bit offset, the ignored timeout and divider offsets and unmapped offsets such as 0x30 and 0x44 can be written. A behavioural model of the three registers is compared on every clock, so the set-versus-clear collision and the all-ones debug nibble are each checked in the cycle they happen.

// File: rtl/sd_host_status_pkg.sv
package sd_host_status_pkg;

    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int STS_N = 11;
    localparam int CFG_N = 11;

    localparam logic [AW-1:0] OFS_STATUS = 8'h20;
    localparam logic [AW-1:0] OFS_DEBUG  = 8'h34;
    localparam logic [AW-1:0] OFS_CONFIG = 8'h38;
    localparam logic [AW-1:0] OFS_TOUT   = 8'h08;
    localparam logic [AW-1:0] OFS_CDIV   = 8'h0C;

    localparam logic [STS_N-1:0] STS_IMPL = 11'h7F9;
    localparam logic [STS_N-1:0] STS_IRQ  = 11'h700;
    localparam logic [CFG_N-1:0] CFG_IMPL = 11'h53F;
    localparam logic [DW-1:0]    DBG_RST  = 32'h0000_C60F;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CONFIG,
        SEL_DEBUG,
        SEL_DROP
    } reg_sel_e;

    typedef struct packed {
        logic sts;
        logic cfg;
        logic dbg;
    } wr_hit_t;

    function automatic reg_sel_e decode_ofs(input logic [AW-1:0] a);
        case (a)
            OFS_STATUS:         return SEL_STATUS;
            OFS_CONFIG:         return SEL_CONFIG;
            OFS_DEBUG:          return SEL_DEBUG;
            OFS_TOUT, OFS_CDIV: return SEL_DROP;
            default:            return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DW-1:0] dbg_filter(input logic [DW-1:0] v);
        logic [DW-1:0] r;
        r = v;
        if (v[3:0] == 4'hF) r[3:0] = 4'h0;
        return r;
    endfunction

endpackage

// File: rtl/sd_host_status_decode.sv
module sd_host_status_decode
    import sd_host_status_pkg::*;
#(
    parameter int ADDR_W = AW
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel,
    output wr_hit_t           hit
);
    always_comb begin
        sel     = decode_ofs(bus_addr);
        hit.sts = bus_wr && (sel == SEL_STATUS);
        hit.cfg = bus_wr && (sel == SEL_CONFIG);
        hit.dbg = bus_wr && (sel == SEL_DEBUG);
    end
endmodule

// File: rtl/sd_host_status_flags.sv
module sd_host_status_flags
    import sd_host_status_pkg::*;
#(
    parameter int               NBITS  = STS_N,
    parameter logic [NBITS-1:0] IMPL   = STS_IMPL,
    parameter logic [NBITS-1:0] IRQMSK = STS_IRQ
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_en,
    input  logic [NBITS-1:0] clr_val,
    input  logic [NBITS-1:0] set_val,
    output logic [NBITS-1:0] flags,
    output logic             irq
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 1'b0;
                else if (set_val[i])
                    q <= 1'b1;
                else if (clr_en && clr_val[i])
                    q <= 1'b0;
            end
            assign flags[i] = q;
        end else begin : g_rsvd
            assign flags[i] = 1'b0;
        end
    end

    assign irq = |(flags & IRQMSK);
endmodule

// File: rtl/sd_host_status_ctrl.sv
module sd_host_status_ctrl
    import sd_host_status_pkg::*;
#(
    parameter int                CFG_W  = CFG_N,
    parameter logic [CFG_W-1:0]  CMASK  = CFG_IMPL,
    parameter int                DATA_W = DW,
    parameter logic [DATA_W-1:0] DRST   = DBG_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_hit_t           hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [DATA_W-1:0] dbg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            dbg_q <= DRST;
        end else begin
            if (hit.cfg) cfg_q <= wdata[CFG_W-1:0] & CMASK;
            if (hit.dbg) dbg_q <= dbg_filter(wdata);
        end
    end
endmodule

// File: rtl/sd_host_status_rdmux.sv
module sd_host_status_rdmux
    import sd_host_status_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int STS_W  = STS_N,
    parameter int CFG_W  = CFG_N
) (
    input  reg_sel_e          sel,
    input  logic [STS_W-1:0]  sts,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [DATA_W-1:0] dbg,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS: rdata[STS_W-1:0] = sts;
            SEL_CONFIG: rdata[CFG_W-1:0] = cfg;
            SEL_DEBUG:  rdata = dbg;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/sd_host_status.sv
module sd_host_status
    import sd_host_status_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW,
    parameter int STS_W  = STS_N,
    parameter int CFG_W  = CFG_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [STS_W-1:0]  sts_set,
    output logic [CFG_W-1:0]  cfg_out,
    output logic [DATA_W-1:0] dbg_out,
    output logic              irq
);
    reg_sel_e         sel;
    wr_hit_t          hit;
    logic [STS_W-1:0] sts_q;

    sd_host_status_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .sel      (sel),
        .hit      (hit)
    );

    sd_host_status_flags #(.NBITS(STS_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_en  (hit.sts),
        .clr_val (bus_wdata[STS_W-1:0]),
        .set_val (sts_set),
        .flags   (sts_q),
        .irq     (irq)
    );

    sd_host_status_ctrl #(.CFG_W(CFG_W), .DATA_W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .wdata (bus_wdata),
        .cfg_q (cfg_out),
        .dbg_q (dbg_out)
    );

    sd_host_status_rdmux #(.DATA_W(DATA_W), .STS_W(STS_W), .CFG_W(CFG_W)) u_rd (
        .sel   (sel),
        .sts   (sts_q),
        .cfg   (cfg_out),
        .dbg   (dbg_out),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/sd_host_status_chk.sv
module sd_host_status_chk
    import sd_host_status_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [STS_N-1:0] sts_set,
    input logic [STS_N-1:0] sts_q,
    input logic [CFG_N-1:0] cfg_out,
    input logic [DW-1:0] dbg_out,
    input logic          irq
);
    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sts_q == '0 && cfg_out == '0 && dbg_out == DBG_RST && !irq));

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        ((sts_set & STS_IMPL) != '0) |=>
        ((sts_q & $past(sts_set & STS_IMPL)) == $past(sts_set & STS_IMPL)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_STATUS) |=>
        ((sts_q & $past(bus_wdata[STS_N-1:0] & ~sts_set)) == '0));

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (sts_q[10:8] == 3'b000) |-> !irq);

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|sts_set[10:8]));

    assert_dbg_nibble_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DEBUG) |=> (dbg_out[3:0] != 4'hF));

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == OFS_CONFIG || bus_addr == OFS_DEBUG)) |=>
        ($stable(cfg_out) && $stable(dbg_out)));

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        sts_q[2:1] == 2'b00);
endmodule

bind sd_host_status sd_host_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sts_set   (sts_set),
    .sts_q     (sts_q),
    .cfg_out   (cfg_out),
    .dbg_out   (dbg_out),
    .irq       (irq)
);

// File: tb/sd_host_status_tb.sv
module sd_host_status_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [10:0] sts_set = 11'h0;
    logic [10:0] cfg_out;
    logic [31:0] dbg_out;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int unsigned m_sts = 0;
    int unsigned m_cfg = 0;
    int unsigned m_dbg = 32'h0000C60F;

    always #10 clk = ~clk;

    sd_host_status dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sts_set   (sts_set),
        .cfg_out   (cfg_out),
        .dbg_out   (dbg_out),
        .irq       (irq)
    );

    function automatic int unsigned exp_read(input logic [7:0] a);
        case (a)
            8'h20:   return m_sts;
            8'h38:   return m_cfg;
            8'h34:   return m_dbg;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sts = 0; m_cfg = 0; m_dbg = 32'h0000C60F;
        end else begin
            if (bus_wr && bus_addr == 8'h20) m_sts = m_sts & ~bus_wdata;
            m_sts = (m_sts | sts_set) & 32'h7F9;
            if (bus_wr && bus_addr == 8'h38) m_cfg = bus_wdata & 32'h53F;
            if (bus_wr && bus_addr == 8'h34)
                m_dbg = ((bus_wdata & 32'hF) == 32'hF) ? (bus_wdata & ~32'hF) : bus_wdata;
        end
    end

    task automatic compare_all(input string tag);
        chk({tag, " irq"}, irq, ((m_sts & 32'h700) != 0) ? 1 : 0);
        chk({tag, " cfg"}, cfg_out, m_cfg);
        chk({tag, " dbg"}, dbg_out, m_dbg);
        chk({tag, " rdata"}, bus_rdata, exp_read(bus_addr));
    endtask

    task automatic cyc(input string tag, input bit wr, input logic [7:0] a,
                       input logic [31:0] d, input logic [10:0] s);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; sts_set = s;
        @(negedge clk);
        compare_all(tag);
        bus_wr = 1'b0; sts_set = 11'h0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        @(negedge clk);
        bus_wr = 1'b0; sts_set = 11'h0; bus_addr = a;
        #1;
        compare_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rd("R1 reset status", 8'h20);
        rd("R1 reset debug", 8'h34);
        @(negedge clk); rst = 1'b0;
        rd("R1 after reset cfg", 8'h38);
        rd("R1 after reset debug", 8'h34);

        cyc("R2 set busy", 1'b0, 8'h20, 0, 11'h400);
        rd("R2 busy held", 8'h20);
        cyc("R3 clear busy", 1'b1, 8'h20, 32'h400, 11'h0);
        cyc("R5 errors no irq", 1'b0, 8'h20, 0, 11'h0F9);
        rd("R5 errors read", 8'h20);
        cyc("R3 partial clear", 1'b1, 8'h20, 32'h040, 11'h0);
        cyc("R3 zeros keep", 1'b1, 8'h20, 32'h0, 11'h0);
        cyc("R5 block irq", 1'b0, 8'h20, 0, 11'h200);
        cyc("R5 data irq", 1'b0, 8'h20, 0, 11'h100);
        cyc("R3 clear block only", 1'b1, 8'h20, 32'h200, 11'h0);
        cyc("R4 set wins", 1'b1, 8'h20, 32'h7FF, 11'h100);
        rd("R4 readback", 8'h20);
        cyc("R3 clear all", 1'b1, 8'h20, 32'hFFFFFFFF, 11'h0);
        cyc("R9 reserved bits", 1'b0, 8'h20, 0, 11'h006);
        rd("R9 reserved read", 8'h20);

        cyc("R6 cfg all ones", 1'b1, 8'h38, 32'hFFFFFFFF, 11'h0);
        cyc("R6 cfg pattern", 1'b1, 8'h38, 32'h0000_0512, 11'h0);
        cyc("R7 debug nibble F", 1'b1, 8'h34, 32'h1234567F, 11'h0);
        cyc("R7 debug plain", 1'b1, 8'h34, 32'h0000ABCD, 11'h0);
        cyc("R7 debug nibble E", 1'b1, 8'h34, 32'h0000000E, 11'h0);

        cyc("R8 timeout write", 1'b1, 8'h08, 32'hFFFFFFFF, 11'h0);
        cyc("R8 divider write", 1'b1, 8'h0C, 32'h000007FF, 11'h0);
        cyc("R8 unmapped 0x44", 1'b1, 8'h44, 32'hFFFFFFFF, 11'h0);
        cyc("R8 unmapped 0x30", 1'b1, 8'h30, 32'h00000001, 11'h0);
        rd("R8 read 0x08", 8'h08);

        cyc("R10 set then read", 1'b0, 8'h20, 0, 11'h481);
        rd("R10 status", 8'h20);
        rd("R10 config", 8'h38);
        rd("R10 debug", 8'h34);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R1 second reset status", 8'h20);
        rd("R1 second reset debug", 8'h34);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule